// File: doc/BRIEF.md
# Two-Phase Hyperbolic Vectoring Magnitude Unit

This block returns the square root of the difference of two squares, sqrt(x² − y²), for a pair of signed 8-bit operands. It uses only shifts and additions. A single hyperbolic micro-rotation datapath is reused across 18 steps. The first phase has six steps and the second has twelve. A fixed shift-add gain stage then removes the hyperbolic shrink factor. A client places x and y on the inputs and pulses `start_i`. When `done_o` pulses, the client reads `mag_o` and `invalid_o`.

Before the first micro-rotation, the controller applies an early correction step called the range fold. It forms p = x − |y| and q = x + |y|. The product p·q equals x² − y². It then repeatedly doubles p and halves q until q ≤ 4p. After that it seeds the rotation with ((q+p)/2, (q−p)/2). This keeps the residual ratio at or below 0.6, so the pair stays inside the convergence range of the step schedule even when |y| is one below x. The schedule uses shift indices 1,2,3,4,4,5 in phase one and 6..13,13,14,15,16 in phase two.

The controller is a state machine with seven states, each with fixed exits:
- IDLE → CHECK when start arrives.
- CHECK → IDLE on a rejected pair, with a done pulse, or CHECK → FOLD otherwise.
- FOLD → FOLD while 4p < q, else FOLD → SEED.
- SEED → PH1.
- PH1 → PH2 after six steps.
- PH2 → SCALE after twelve steps.
- SCALE → IDLE with a done pulse.

Top module: `hvc_sqdiff`

## Requirements
- R1: During and directly after reset, `done_o`, `invalid_o` and `mag_o` are all zero.
- R2: For two's-complement operands with |y| < x, `mag_o` read as an unsigned value with 18 fractional bits is within 2·10⁻⁴·E + 256 LSB of E = sqrt(x² − y²)·2¹⁸, and `invalid_o` is 0.
- R3: When |y| ≥ x (this covers every x ≤ 0), `done_o` rises exactly 1 cycle after the start edge, with `invalid_o` = 1 and `mag_o` = 0.
- R4: A valid pair raises `done_o` exactly 22 + j cycles after the start edge. Here j is the smallest non-negative integer with x + |y| ≤ 4^(j+1)·(x − |y|).
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: A start presented while an operation is in progress is ignored. The running result is unaffected and no extra done pulse follows.
- R7: `mag_o` and `invalid_o` change only in a cycle where `done_o` is high, and they hold their value until the next done pulse.
- R8: A start presented in the same cycle that `done_o` is high is accepted, and it produces its own correct result with the latency of R4.
- R9: `mag_o` for (x, y) is bit-identical to `mag_o` for (x, −y).
- R10: The accuracy bound of R2 also holds at the domain edge |y| = x − 1 for every x from 2 to 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request, sampled in IDLE only |
| x_i | input | 8 | Operand x, two's complement |
| y_i | input | 8 | Operand y, two's complement |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Set when the last pair had abs(y) ≥ x |
| mag_o | output | 27 | sqrt(x²−y²), unsigned, 18 fractional bits |

## Verification
The result update with its done pulse, and the acceptance of a new request, can land in the same cycle. The controller is back in IDLE exactly while `done_o` is high. The bench raises `start_i` on the very cycle it sees `done_o`. It then judges three things: the first result is captured intact, the new result arrives after exactly 22 + j cycles with the right value, and the old value is still held in the middle of the second operation. A start raised mid-operation is checked separately, so that acceptance-at-done is distinguished from acceptance-while-busy.

// File: rtl/hvc_pkg.sv
package hvc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FOLD,
        ST_SEED,
        ST_PH1,
        ST_PH2,
        ST_SCALE
    } hvc_state_t;

    // Per-cycle control strobes from the sequencer to the datapath
    typedef struct packed {
        logic cap;      // latch operands
        logic reject;   // pair out of domain
        logic fold_ld;  // load p and q
        logic fold_sh;  // balance p and q by a factor of four
        logic seed;     // form the rotation start vector
        logic rot;      // one micro-rotation
        logic scale;    // gain correction and result latch
    } hvc_ctl_t;

    // Shift index for a step: counts up from 1, with the two
    // convergence indices visited twice.
    function automatic int hvc_shift_of(input int step, input int rep_lo, input int rep_hi);
        int idx;
        idx = step + 1;
        if (step >= rep_lo)     idx = idx - 1;
        if (step >= rep_hi + 1) idx = idx - 1;
        return idx;
    endfunction

endpackage

// File: rtl/hvc_microrot.sv
module hvc_microrot #(
    parameter int W    = 29,
    parameter int SH_W = 5
) (
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic        [SH_W-1:0] shift_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o
);

    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;
    logic                y_nonneg;

    assign x_sh     = x_i >>> shift_i;
    assign y_sh     = y_i >>> shift_i;
    assign y_nonneg = ~y_i[W-1];

    // Drive y toward zero; hyperbolic form mixes with like signs
    always_comb begin
        if (y_nonneg) begin
            x_o = x_i - y_sh;
            y_o = y_i - x_sh;
        end else begin
            x_o = x_i + y_sh;
            y_o = y_i + x_sh;
        end
    end

endmodule

// File: rtl/hvc_gain.sv
module hvc_gain #(
    parameter int          W        = 29,
    parameter int          NTERM    = 16,
    parameter logic [15:0] GAIN_POS = 16'h0959,
    parameter logic [15:0] GAIN_NEG = 16'h0000
) (
    input  logic signed [W-1:0] raw_i,
    output logic signed [W:0]   scaled_o
);

    logic signed [W:0] raw_ext;
    logic signed [W:0] term [NTERM];

    assign raw_ext = {raw_i[W-1], raw_i};

    // Each set mask bit k contributes +/- raw * 2^-k
    genvar k;
    for (k = 0; k < NTERM; k++) begin : g_term
        if (GAIN_POS[k]) begin : g_pos
            assign term[k] = raw_ext >>> k;
        end else if (GAIN_NEG[k]) begin : g_neg
            assign term[k] = -(raw_ext >>> k);
        end else begin : g_nil
            assign term[k] = '0;
        end
    end

    always_comb begin
        scaled_o = '0;
        for (int i = 0; i < NTERM; i++) begin
            scaled_o = scaled_o + term[i];
        end
    end

endmodule

// File: rtl/hvc_ctrl.sv
module hvc_ctrl
    import hvc_pkg::*;
#(
    parameter int ITER_A = 6,
    parameter int ITER_B = 12,
    parameter int REP_LO = 4,
    parameter int REP_HI = 13,
    parameter int SH_W   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            reject_i,
    input  logic            fold_more_i,
    output hvc_ctl_t        ctl_o,
    output logic [SH_W-1:0] shift_o,
    output logic            done_o
);

    localparam int N_STEP = ITER_A + ITER_B;

    hvc_state_t      state_q, state_d;
    logic [SH_W-1:0] step_q;
    logic            last_a;
    logic            last_b;

    assign last_a = (step_q == SH_W'(ITER_A - 1));
    assign last_b = (step_q == SH_W'(N_STEP - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = reject_i ? ST_IDLE : ST_FOLD;
            ST_FOLD:  if (!fold_more_i) state_d = ST_SEED;
            ST_SEED:  state_d = ST_PH1;
            ST_PH1:   if (last_a) state_d = ST_PH2;
            ST_PH2:   if (last_b) state_d = ST_SCALE;
            ST_SCALE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_IDLE:  ctl_o.cap     = start_i;
            ST_CHECK: begin
                ctl_o.reject  = reject_i;
                ctl_o.fold_ld = ~reject_i;
            end
            ST_FOLD:  ctl_o.fold_sh = fold_more_i;
            ST_SEED:  ctl_o.seed    = 1'b1;
            ST_PH1:   ctl_o.rot     = 1'b1;
            ST_PH2:   ctl_o.rot     = 1'b1;
            ST_SCALE: ctl_o.scale   = 1'b1;
            default:  ctl_o = '0;
        endcase
        shift_o = SH_W'(hvc_shift_of(int'(step_q), REP_LO, REP_HI));
    end

    // Step counter across both phases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (state_q == ST_SEED) begin
            step_q <= '0;
        end else if (state_q == ST_PH1 || state_q == ST_PH2) begin
            step_q <= step_q + 1'b1;
        end
    end

    // Registered completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_SCALE) || (state_q == ST_CHECK && reject_i);
    end

endmodule

// File: rtl/hvc_sqdiff.sv
module hvc_sqdiff
    import hvc_pkg::*;
#(
    parameter int          IN_W     = 8,
    parameter int          FRAC     = 18,
    parameter int          OUT_W    = 27,
    parameter int          ITER_A   = 6,
    parameter int          ITER_B   = 12,
    parameter int          REP_LO   = 4,
    parameter int          REP_HI   = 13,
    parameter logic [15:0] GAIN_POS = 16'h0959,
    parameter logic [15:0] GAIN_NEG = 16'h0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] y_i,
    output logic                   done_o,
    output logic                   invalid_o,
    output logic [OUT_W-1:0]       mag_o
);

    localparam int W      = IN_W + FRAC + 3;
    localparam int GAP    = W - IN_W - 2 - FRAC;
    localparam int N_STEP = ITER_A + ITER_B;
    localparam int SH_W   = $clog2(N_STEP + 1);

    hvc_ctl_t               ctl;
    logic [SH_W-1:0]        shift;
    logic signed [IN_W-1:0] xin_q, yin_q;
    logic signed [IN_W:0]   y_abs;
    logic signed [IN_W+1:0] p_raw, q_raw;
    logic signed [W-1:0]    p_sc, q_sc;
    logic signed [W-1:0]    p_q, q_q;
    logic signed [W-1:0]    xr_q, yr_q;
    logic signed [W-1:0]    x_nx, y_nx;
    logic signed [W:0]      gained;
    logic [OUT_W-1:0]       mag_sat;
    logic [OUT_W-1:0]       mag_q;
    logic                   inv_q;
    logic                   reject;
    logic                   fold_more;

    // Domain test and the product-preserving pair p, q
    always_comb begin
        y_abs = yin_q[IN_W-1] ? -{yin_q[IN_W-1], yin_q} : {yin_q[IN_W-1], yin_q};
        p_raw = {{2{xin_q[IN_W-1]}}, xin_q} - {y_abs[IN_W], y_abs};
        q_raw = {{2{xin_q[IN_W-1]}}, xin_q} + {y_abs[IN_W], y_abs};
        reject = p_raw[IN_W+1] || (p_raw == '0);
        p_sc  = {{GAP{p_raw[IN_W+1]}}, p_raw, {FRAC{1'b0}}};
        q_sc  = {{GAP{q_raw[IN_W+1]}}, q_raw, {FRAC{1'b0}}};
    end

    assign fold_more = (p_q <<< 2) < q_q;

    hvc_ctrl #(
        .ITER_A (ITER_A),
        .ITER_B (ITER_B),
        .REP_LO (REP_LO),
        .REP_HI (REP_HI),
        .SH_W   (SH_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .reject_i    (reject),
        .fold_more_i (fold_more),
        .ctl_o       (ctl),
        .shift_o     (shift),
        .done_o      (done_o)
    );

    hvc_microrot #(
        .W    (W),
        .SH_W (SH_W)
    ) u_rot (
        .x_i     (xr_q),
        .y_i     (yr_q),
        .shift_i (shift),
        .x_o     (x_nx),
        .y_o     (y_nx)
    );

    hvc_gain #(
        .W        (W),
        .NTERM    (16),
        .GAIN_POS (GAIN_POS),
        .GAIN_NEG (GAIN_NEG)
    ) u_gain (
        .raw_i    (xr_q),
        .scaled_o (gained)
    );

    // Clamp the corrected magnitude into the unsigned output field
    always_comb begin
        if (gained[W]) begin
            mag_sat = '0;
        end else if (|gained[W-1:OUT_W]) begin
            mag_sat = '1;
        end else begin
            mag_sat = gained[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xin_q <= '0;
            yin_q <= '0;
            p_q   <= '0;
            q_q   <= '0;
            xr_q  <= '0;
            yr_q  <= '0;
            mag_q <= '0;
            inv_q <= 1'b0;
        end else begin
            if (ctl.cap) begin
                xin_q <= x_i;
                yin_q <= y_i;
            end
            if (ctl.fold_ld) begin
                p_q <= p_sc;
                q_q <= q_sc;
            end else if (ctl.fold_sh) begin
                p_q <= p_q <<< 1;
                q_q <= q_q >>> 1;
            end
            if (ctl.seed) begin
                xr_q <= (q_q + p_q) >>> 1;
                yr_q <= (q_q - p_q) >>> 1;
            end else if (ctl.rot) begin
                xr_q <= x_nx;
                yr_q <= y_nx;
            end
            if (ctl.scale) begin
                mag_q <= mag_sat;
                inv_q <= 1'b0;
            end else if (ctl.reject) begin
                mag_q <= '0;
                inv_q <= 1'b1;
            end
        end
    end

    assign mag_o     = mag_q;
    assign invalid_o = inv_q;

endmodule

// File: rtl/hvc_sqdiff_chk.sv
module hvc_sqdiff_chk #(
    parameter int OUT_W   = 27,
    parameter int LAT_MIN = 22,
    parameter int LAT_MAX = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             invalid_o,
    input logic [OUT_W-1:0] mag_o
);

    logic       busy;
    logic [7:0] cnt;

    // Port-level model of an operation in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start_i && (!busy || done_o)) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done_o) begin
            busy <= 1'b0;
        end else if (busy && cnt != 8'hFF) begin
            cnt <= cnt + 8'd1;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy);

    // R7
    hold_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mag_o) |-> done_o);

    // R7
    hold_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(invalid_o) |-> done_o);

    // R3
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (mag_o == '0));

    // R3
    inv_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && invalid_o) |-> (cnt == 8'd1));

    // R4
    ok_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !invalid_o) |-> (cnt >= 8'(LAT_MIN) && cnt <= 8'(LAT_MAX)));

endmodule

bind hvc_sqdiff hvc_sqdiff_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .done_o    (done_o),
    .invalid_o (invalid_o),
    .mag_o     (mag_o)
);

// File: tb/hvc_sqdiff_tb.sv
module hvc_sqdiff_tb;

    localparam real ONE = 262144.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic signed [7:0] x_i = '0;
    logic signed [7:0] y_i = '0;
    logic              done_o;
    logic              invalid_o;
    logic [26:0]       mag_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hvc_sqdiff u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .x_i       (x_i),
        .y_i       (y_i),
        .done_o    (done_o),
        .invalid_o (invalid_o),
        .mag_o     (mag_o)
    );

    task automatic note(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fold_count(input int xv, input int yv);
        int ay, p, q, j;
        ay = (yv < 0) ? -yv : yv;
        p = xv - ay;
        q = xv + ay;
        j = 0;
        while (q > (p << (2 * (j + 1)))) j++;
        return j;
    endfunction

    task automatic run_op(input int xv, input int yv, output int lat,
                          output longint mag, output bit inv);
        @(negedge clk);
        x_i = 8'(xv);
        y_i = 8'(yv);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (done_o !== 1'b1 && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        mag = longint'(mag_o);
        inv = invalid_o;
        @(negedge clk);
        note(done_o === 1'b0, "R5", "done one cycle", longint'(done_o), 0);
    endtask

    task automatic check_ok(input int xv, input int yv, input string tag, output longint mag);
        int lat;
        bit inv;
        real exp, tol, err;
        run_op(xv, yv, lat, mag, inv);
        exp = $sqrt(real'(xv * xv - yv * yv)) * ONE;
        tol = exp * 2.0e-4 + 256.0;
        err = real'(mag) - exp;
        if (err < 0.0) err = -err;
        note(err <= tol, tag, "magnitude", mag, $rtoi(exp));
        note(inv == 1'b0, "R3", "invalid on valid pair", longint'(inv), 0);
        note(lat == 22 + fold_count(xv, yv), "R4", "latency", lat, 22 + fold_count(xv, yv));
    endtask

    task automatic check_bad(input int xv, input int yv);
        int lat;
        longint mag;
        bit inv;
        run_op(xv, yv, lat, mag, inv);
        note(inv == 1'b1, "R3", "invalid flag", longint'(inv), 1);
        note(mag == 0, "R3", "zero result", mag, 0);
        note(lat == 1, "R3", "reject latency", lat, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        note(1'b0, "R4", "watchdog expired", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint ma, mb, m0;
        int lat;
        int ay;

        // R1: reset state
        repeat (3) @(negedge clk);
        note(done_o === 1'b0, "R1", "done in reset", longint'(done_o), 0);
        note(invalid_o === 1'b0, "R1", "invalid in reset", longint'(invalid_o), 0);
        note(mag_o === '0, "R1", "mag in reset", longint'(mag_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        note(done_o === 1'b0 && mag_o === '0, "R1", "after release", longint'(mag_o), 0);

        // R2 / R3: sweep of the operand plane
        for (int xv = 1; xv <= 127; xv += 3) begin
            for (int yv = -xv; yv <= xv; yv += 4) begin
                ay = (yv < 0) ? -yv : yv;
                if (ay < xv) check_ok(xv, yv, "R2", ma);
                else         check_bad(xv, yv);
            end
        end

        // R3: out-of-domain corners
        check_bad(0, 0);
        check_bad(-128, 0);
        check_bad(-5, 3);
        check_bad(127, -128);
        check_bad(127, 127);
        check_bad(1, -1);

        // R10 and R9: domain edge, both signs of y
        for (int xv = 2; xv <= 127; xv++) begin
            check_ok(xv, xv - 1, "R10", ma);
            check_ok(xv, -(xv - 1), "R10", mb);
            note(ma == mb, "R9", "sign symmetry", mb, ma);
        end
        check_ok(127, 0, "R2", ma);
        check_ok(1, 0, "R2", ma);

        // R6: start while busy is ignored
        @(negedge clk);
        x_i = 8'sd100;
        y_i = 8'sd60;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (done_o !== 1'b1 && lat < 64) begin
            @(negedge clk);
            lat++;
            if (lat == 5) begin
                x_i = 8'sd50;
                y_i = 8'sd10;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        note(lat == 22 + fold_count(100, 60), "R6", "latency with busy start", lat, 22);
        note(mag_o >= 27'd20970000 && mag_o <= 27'd20973000, "R6", "first result kept",
             longint'(mag_o), 20971520);
        m0 = longint'(mag_o);
        // R7: no further pulse, result held
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done_o !== 1'b0) note(1'b0, "R6", "stray done", 1, 0);
        end
        note(longint'(mag_o) == m0, "R7", "result held", longint'(mag_o), m0);

        // R8: new start in the done cycle
        @(negedge clk);
        x_i = 8'sd90;
        y_i = -8'sd30;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (done_o !== 1'b1 && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        ma = longint'(mag_o);
        x_i = 8'sd64;
        y_i = 8'sd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        note(done_o === 1'b0, "R5", "done after back-to-back", longint'(done_o), 0);
        lat = 0;
        while (done_o !== 1'b1 && lat < 64) begin
            @(negedge clk);
            lat++;
            if (lat == 10) note(longint'(mag_o) == ma, "R7", "old result during run",
                                longint'(mag_o), ma);
        end
        note(lat == 22, "R8", "back-to-back latency", lat, 22);
        note(mag_o >= 27'd16770000 && mag_o <= 27'd16785000, "R8", "back-to-back value",
             longint'(mag_o), 16777216);
        note(invalid_o === 1'b0, "R8", "back-to-back flag", longint'(invalid_o), 0);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule